// File: doc/BRIEF.md
# DDS Serial Configuration Sequencer

This block is a write-only serial master that brings up an external direct-digital-synthesis generator and programs its output. A single-cycle start strobe captures a 28-bit tuning word and a two-bit waveform code. The block then sends four 16-bit command frames. The first is a control word that holds the synthesizer in reset with sine output. The second is a control word that releases reset and picks the requested waveform. The last two are frequency frames that carry the two 14-bit halves of the tuning word.

Each frame is framed on its own by an active-low sync line. Bits leave most significant first and are taken by the receiver on the falling edge of the serial clock. The serial clock toggles once per tick of a free-running divider of the system clock. `busy` covers the whole sequence, and `done` pulses once when the last frame has ended. The tuning word is supplied already scaled: it is the output frequency times 2^28 divided by the synthesizer's 25 MHz master clock. For example, 12.5 MHz corresponds to 0x8000000.

Top module: `dds_cfg_seq`

## Requirements
- R1: After reset, `sclk` = 1, `fsync_n` = 1, `busy` = 0 and `done` = 0.
- R2: Each frame carries exactly 16 bits, most significant first. `sdata` holds its value across every falling `sclk` edge, and there are exactly 16 falling edges per frame.
- R3: `sclk` is high whenever `fsync_n` is high and toggles only while `fsync_n` is low. `fsync_n` falls with `sclk` high and rises after the final rising `sclk` edge.
- R4: The first frame of every sequence is 0x2100 (reset held, sine selected).
- R5: The second frame depends on `wave_sel`: 2'b00 gives 0x2000 (sine), 2'b01 gives 0x2002 (triangle), 2'b10 gives 0x2028 (square), and 2'b11 gives 0x2000.
- R6: The third frame is {2'b01, tuning_word[13:0]} and the fourth is {2'b01, tuning_word[27:14]}. Bits 15:14 = 01 select frequency register 0.
- R7: Between two frames of one sequence, `fsync_n` stays high for at least two `sclk` half-periods (2*HALF_DIV clocks).
- R8: `done` is high for exactly one clock after the fourth frame has ended, and `busy` falls in that same cycle.
- R9: A start strobe that arrives while `busy` is high is ignored, and `busy` stays high until `done` pulses.
- R10: Every `sclk` half-period, and the delay from the fall of `fsync_n` to the first `sclk` edge, lasts exactly HALF_DIV system clocks.
- R11: `tuning_word` and `wave_sel` are captured on the accepted start. Changes to them during a sequence do not alter the frames being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a configuration sequence |
| tuning_word | input | 28 | Pre-scaled frequency tuning word |
| wave_sel | input | 2 | Waveform code: 00 sine, 01 triangle, 10 square, 11 sine |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, MSB first |
| fsync_n | output | 1 | Active-low frame sync |
| busy | output | 1 | High while a sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The assertions assume that `start` is sampled only on rising clock edges and that reset is applied synchronously before the first strobe. They place no constraint on how `start` relates to `busy`. The stimulus therefore fires extra strobes at random points inside running sequences and scrambles `tuning_word` and `wave_sel` after each accepted start. A bench-side receiver samples `sdata` on every falling `sclk` edge and rebuilds the frames. It also times the half-periods and the gaps between frames in system clocks, and compares every rebuilt word with values computed from the captured inputs.

// File: rtl/dds_cfg_pkg.sv
package dds_cfg_pkg;

    localparam int FRAME_W    = 16;
    localparam int TUNE_W     = 28;
    localparam int HALF_W     = TUNE_W / 2;
    localparam int NUM_FRAMES = 4;
    localparam int STEP_W     = 6;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [NUM_FRAMES-1:0][FRAME_W-1:0] frame_set_t;

    typedef enum logic [1:0] {
        WAVE_SINE   = 2'b00,
        WAVE_TRI    = 2'b01,
        WAVE_SQUARE = 2'b10,
        WAVE_RSVD   = 2'b11
    } wave_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_WAIT
    } seq_state_e;

    localparam frame_t     CTRL_RESET  = 16'h2100;
    localparam frame_t     MODE_SINE   = 16'h2000;
    localparam frame_t     MODE_TRI    = 16'h2002;
    localparam frame_t     MODE_SQUARE = 16'h2028;
    localparam logic [1:0] FREQ0_TAG   = 2'b01;

    function automatic frame_t mode_frame(wave_e w);
        case (w)
            WAVE_TRI:    return MODE_TRI;
            WAVE_SQUARE: return MODE_SQUARE;
            default:     return MODE_SINE;
        endcase
    endfunction

    function automatic frame_set_t build_frames(logic [TUNE_W-1:0] tw, wave_e w);
        frame_set_t fs;
        fs[0] = CTRL_RESET;
        fs[1] = mode_frame(w);
        fs[2] = {FREQ0_TAG, tw[HALF_W-1:0]};
        fs[3] = {FREQ0_TAG, tw[TUNE_W-1:HALF_W]};
        return fs;
    endfunction

endpackage

// File: rtl/dds_tick_div.sv
module dds_tick_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == CNT_MAX) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == CNT_MAX);

    generate
        if (HALF_DIV > 1) begin : g_spaced
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R10
        end
    endgenerate

endmodule

// File: rtl/dds_frame_shifter.sv
module dds_frame_shifter
    import dds_cfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   load,
    input  frame_t word,
    output logic   sclk,
    output logic   sdata,
    output logic   fsync_n,
    output logic   frame_done
);
    localparam logic [STEP_W-1:0] STEP_LAST_FALL = STEP_W'(2 * FRAME_W - 1);
    localparam logic [STEP_W-1:0] STEP_LAST_RISE = STEP_W'(2 * FRAME_W);
    localparam logic [STEP_W-1:0] STEP_SYNC_UP   = STEP_W'(2 * FRAME_W + 1);
    localparam logic [STEP_W-1:0] STEP_END       = STEP_W'(2 * FRAME_W + 3);

    logic              active;
    logic [STEP_W-1:0] step;
    frame_t            shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            step       <= '0;
            shreg      <= '0;
            sclk       <= 1'b1;
            sdata      <= 1'b0;
            fsync_n    <= 1'b1;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (!active) begin
                if (load) begin
                    active <= 1'b1;
                    shreg  <= word;
                    step   <= '0;
                end
            end else if (tick) begin
                step <= step + 1'b1;
                if (step == '0) begin
                    fsync_n <= 1'b0;
                    sclk    <= 1'b1;
                    sdata   <= shreg[FRAME_W-1];
                end else if (step <= STEP_LAST_FALL && step[0]) begin
                    sclk <= 1'b0;
                end else if (step < STEP_LAST_RISE) begin
                    sclk  <= 1'b1;
                    sdata <= shreg[FRAME_W-2];
                    shreg <= shreg << 1;
                end else if (step == STEP_LAST_RISE) begin
                    sclk <= 1'b1;
                end else if (step == STEP_SYNC_UP) begin
                    fsync_n <= 1'b1;
                end else if (step == STEP_END) begin
                    active     <= 1'b0;
                    frame_done <= 1'b1;
                    step       <= '0;
                end
            end
        end
    end

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        fsync_n |-> sclk); // R3
    AST_SCLK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk) |-> (!fsync_n && !$past(fsync_n))); // R3
    AST_SDATA_STEADY_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> $stable(sdata)); // R2
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        load |-> !active); // R7

endmodule

// File: rtl/dds_frame_sequencer.sv
module dds_frame_sequencer
    import dds_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TUNE_W-1:0] tuning_word,
    input  logic [1:0]        wave_sel,
    input  logic              frame_done,
    output logic              load,
    output frame_t            load_word,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W = $clog2(NUM_FRAMES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_FRAMES - 1);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    frame_set_t       cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            idx   <= '0;
            cfg_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        cfg_q <= build_frames(tuning_word, wave_e'(wave_sel));
                        idx   <= '0;
                        busy  <= 1'b1;
                        state <= SEQ_LOAD;
                    end
                end
                SEQ_LOAD: state <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (frame_done) begin
                        if (idx == IDX_LAST) begin
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            state <= SEQ_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SEQ_LOAD;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign load      = (state == SEQ_LOAD);
    assign load_word = cfg_q[idx];

    AST_DONE_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(cfg_q)); // R9
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q)); // R11

endmodule

// File: rtl/dds_cfg_seq.sv
module dds_cfg_seq
    import dds_cfg_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [27:0] tuning_word,
    input  logic [1:0]  wave_sel,
    output logic        sclk,
    output logic        sdata,
    output logic        fsync_n,
    output logic        busy,
    output logic        done
);
    logic   tick;
    logic   load;
    logic   frame_done;
    frame_t load_word;

    dds_tick_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dds_frame_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .tuning_word (tuning_word),
        .wave_sel    (wave_sel),
        .frame_done  (frame_done),
        .load        (load),
        .load_word   (load_word),
        .busy        (busy),
        .done        (done)
    );

    dds_frame_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .load       (load),
        .word       (load_word),
        .sclk       (sclk),
        .sdata      (sdata),
        .fsync_n    (fsync_n),
        .frame_done (frame_done)
    );

endmodule

// File: tb/dds_cfg_seq_test.sv
module dds_cfg_seq_test;
    localparam int HALF_DIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [27:0] tuning_word = '0;
    logic [1:0]  wave_sel = '0;
    logic        sclk, sdata, fsync_n, busy, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [15:0] words [0:7];
    int          wcnt = 0;
    int          done_cnt = 0;

    bit          prev_sclk = 1'b1, prev_fs = 1'b1;
    logic [15:0] rx_shift = '0;
    int          nbits = 0;
    int          half_cnt = 0;
    int          gap_cnt = 0;

    always #10 clk = ~clk;

    dds_cfg_seq #(.HALF_DIV(HALF_DIV)) uut (
        .clk(clk), .rst(rst), .start(start), .tuning_word(tuning_word),
        .wave_sel(wave_sel), .sclk(sclk), .sdata(sdata), .fsync_n(fsync_n),
        .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(int i, logic [27:0] tw, logic [1:0] w);
        case (i)
            0: return 16'h2100;
            1: return (w == 2'b01) ? 16'h2002 : (w == 2'b10) ? 16'h2028 : 16'h2000;
            2: return {2'b01, tw[13:0]};
            default: return {2'b01, tw[27:14]};
        endcase
    endfunction

    // Bench-side receiver: samples away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            half_cnt++;
            if (fsync_n) gap_cnt++;
            if (prev_fs && !fsync_n) begin
                if (wcnt > 0 && busy)
                    check(gap_cnt >= 2 * HALF_DIV, "R7 gap", gap_cnt, 2 * HALF_DIV);
                check(sclk == 1'b1, "R3 sclk high at sync fall", sclk, 1);
                nbits = 0;
                rx_shift = '0;
                half_cnt = 0;
            end
            if (!fsync_n && sclk != prev_sclk) begin
                check(half_cnt == HALF_DIV, "R10 half period", half_cnt, HALF_DIV);
                half_cnt = 0;
                if (!sclk) begin
                    rx_shift = {rx_shift[14:0], sdata};
                    nbits++;
                end
            end
            if (fsync_n && !sclk)
                check(1'b0, "R3 sclk low while idle", 0, 1);
            if (!prev_fs || !fsync_n) begin end
            if (!prev_fs && fsync_n) begin
                check(nbits == 16, "R2 bit count", nbits, 16);
                check(sclk == 1'b1, "R3 sclk high at sync rise", sclk, 1);
                if (wcnt < 8) words[wcnt] = rx_shift;
                wcnt++;
                gap_cnt = 1;
            end
            if (done) begin
                done_cnt++;
                check(busy == 1'b0, "R8 busy low with done", busy, 0);
                check(wcnt == 4, "R8 done after fourth frame", wcnt, 4);
            end
            prev_sclk = sclk;
            prev_fs = fsync_n;
        end
    end

    task automatic run_seq(input logic [27:0] tw, input logic [1:0] w, input bit inject);
        int guard;
        @(negedge clk);
        wcnt = 0;
        done_cnt = 0;
        tuning_word = tw;
        wave_sel = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        tuning_word = 28'($urandom);   // R11: scrambled after capture
        wave_sel = 2'($urandom);
        if (inject) begin
            repeat ($urandom_range(3, 150)) @(negedge clk);
            check(busy == 1'b1, "R9 busy before extra start", busy, 1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        check(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
        check(busy == 1'b0, "R9 idle after done", busy, 0);
        check(wcnt == 4, "R2 frame count", wcnt, 4);
        for (int i = 0; i < 4; i++) begin
            case (i)
                0: check(words[i] == exp_word(i, tw, w), "R4 reset frame", words[i], exp_word(i, tw, w));
                1: check(words[i] == exp_word(i, tw, w), "R5 mode frame", words[i], exp_word(i, tw, w));
                default: check(words[i] == exp_word(i, tw, w), "R6 R11 freq frame", words[i], exp_word(i, tw, w));
            endcase
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(sclk == 1'b1, "R1 sclk", sclk, 1);
        check(fsync_n == 1'b1, "R1 fsync_n", fsync_n, 1);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        // Directed: 12.5 MHz sine -> 0x4000 then 0x6000
        run_seq(28'h8000000, 2'b00, 1'b0);
        run_seq(28'h0000000, 2'b01, 1'b0);
        run_seq(28'hFFFFFFF, 2'b10, 1'b1);
        run_seq(28'h0003FFF, 2'b11, 1'b0);
        run_seq(28'hFFFC000, 2'b10, 1'b1);
        for (int n = 0; n < 20; n++)
            run_seq(28'($urandom), 2'($urandom), bit'($urandom_range(0, 1)));
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule